// File: doc/BRIEF.md
# Interlaced Vertical Field Sequencer

This block produces the vertical timing of an interlaced raster with 808 visible lines, shown as two fields of 404 lines each. It counts the scanline-end pulses from the horizontal timing generator. After the visible lines of a field it inserts a programmable run of invisible padding lines, then vertical sync, then a programmable blanking tail, then a fixed run of 14 blank lines. At the end of that run it toggles the field indicator and starts the next field. The padding length sets the field rate: a longer pad lowers the rate without moving the visible picture.

On the odd field, vertical sync starts and ends on the horizontal midline strobe instead of a scanline boundary. This offsets the two fields by half a line, so their lines interlace. The padding, sync and tail lengths are sampled once at the start of each field, so software may rewrite them at any time without tearing the field in progress.

The controller has six states: `ST_ACTIVE` (visible lines), `ST_PAD` (padding), `ST_ALIGN` (odd field only: wait for the midline strobe), `ST_SYNC` (vertical sync), `ST_TAIL` (blanking tail) and `ST_FIXED` (the fixed 14 lines). Its transitions are:
- `ST_ACTIVE`→`ST_PAD` after the last visible line.
- `ST_PAD`→`ST_SYNC` on the even field, or `ST_PAD`→`ST_ALIGN` on the odd field.
- `ST_ALIGN`→`ST_SYNC` on the midline strobe.
- `ST_SYNC`→`ST_TAIL` when the sync count completes.
- `ST_TAIL`→`ST_FIXED` when the tail count completes.
- `ST_FIXED`→`ST_ACTIVE` when the fixed count completes. The field toggles on this transition.

Top module: `vfield_seq`

## Requirements
- R1: During and right after reset, `vblank` and `vsync` are low, `field_odd` is 0 (even field) and `vis_line` is 0.
- R2: Each field starts with 404 visible lines. During them `vblank` is low and `vis_line` counts 0, 1, … 403, advancing on each `line_end` pulse. Outside the visible lines, `vis_line` reads 0.
- R3: After the visible lines come `pad_len` padding lines, with `vblank` high and `vsync` low. A `pad_len` of 0 behaves as 1.
- R4: On the even field, `vsync` rises on the `line_end` that ends the padding and stays high for `sync_len` lines, falling on a `line_end`. A `sync_len` of 0 behaves as 1.
- R5: On the odd field, `vsync` rises on the first `mid_line` strobe after the padding ends. It falls on the `sync_len`-th `mid_line` strobe after that. While `vsync` is high on the odd field, `line_end` pulses still advance the line position but do not end sync.
- R6: After sync come `tail_len` tail lines (0 behaves as 1) and then 14 fixed lines, all with `vblank` high and `vsync` low. A field therefore holds 404 + pad + sync + tail + 14 lines.
- R7: `field_odd` toggles on the `line_end` that ends the last fixed line. `vblank` falls on that same edge.
- R8: `pad_len`, `sync_len` and `tail_len` are sampled at the start of each field. Changes made while a field is running have no effect on that field's timing.
- R9: `vblank` stays high without a gap from the first padding line to the end of the last fixed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | One-cycle pulse at the end of each scanline |
| mid_line | input | 1 | One-cycle pulse at the horizontal midpoint of each scanline; never in the same cycle as `line_end` |
| pad_len | input | 10 | Padding lines inserted before sync |
| sync_len | input | 6 | Vertical sync length in lines |
| tail_len | input | 6 | Blank tail lines after sync |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| field_odd | output | 1 | 1 while the odd field is being scanned |
| vis_line | output | 9 | Visible line index within the field |

## Verification
The sequencer is run for many fields in a row. Each field uses lengths drawn at random from a fixed seed, and scanlines of random width with the midline strobe placed at a random point. This separates a design that counts the wrong event from one that counts the right one. Directed fields use zero lengths, which tests the treatment of 0 as 1. A field with a pad of 139, sync of 9 and tail of 13 and a field with maximum lengths test long counts and counter width. Every field rewrites the lengths partway through, so a design that reads them live rather than once per field shows a wrong blanking length. On alternate fields, checking `vsync` at both half-line positions tells an odd field aligned to the midline apart from one aligned to the line end.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_PAD    = 3'd1,
        ST_ALIGN  = 3'd2,
        ST_SYNC   = 3'd3,
        ST_TAIL   = 3'd4,
        ST_FIXED  = 3'd5
    } vfs_state_e;

endpackage

// File: rtl/vfs_len_latch.sv
module vfs_len_latch #(
    parameter int PAD_W  = 10,
    parameter int SYNC_W = 6,
    parameter int TAIL_W = 6,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAD_W-1:0]  pad_len,
    input  logic [SYNC_W-1:0] sync_len,
    input  logic [TAIL_W-1:0] tail_len,
    output logic [CNT_W-1:0]  pad_last,
    output logic [CNT_W-1:0]  sync_last,
    output logic [CNT_W-1:0]  tail_last
);

    // A programmed length of zero is treated as one line.
    function automatic logic [CNT_W-1:0] last_index(input logic [CNT_W-1:0] len);
        if (len == '0)
            return '0;
        else
            return len - CNT_W'(1);
    endfunction

    logic [CNT_W-1:0] pad_ext;
    logic [CNT_W-1:0] sync_ext;
    logic [CNT_W-1:0] tail_ext;

    always_comb begin
        pad_ext  = CNT_W'(pad_len);
        sync_ext = CNT_W'(sync_len);
        tail_ext = CNT_W'(tail_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_last  <= '0;
            sync_last <= '0;
            tail_last <= '0;
        end else if (load) begin
            pad_last  <= last_index(pad_ext);
            sync_last <= last_index(sync_ext);
            tail_last <= last_index(tail_ext);
        end
    end

    // R8
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(pad_last) && $stable(sync_last) && $stable(tail_last)));

endmodule

// File: rtl/vfs_step_sel.sv
module vfs_step_sel
    import vfs_pkg::*;
(
    input  vfs_state_e state,
    input  logic       field_odd,
    input  logic       line_end,
    input  logic       mid_line,
    output logic       step
);

    // Odd-field sync and its alignment run on midline strobes so
    // that vsync lands half a line away from the even field.
    always_comb begin
        unique case (state)
            ST_ALIGN: step = mid_line;
            ST_SYNC:  step = field_odd ? mid_line : line_end;
            default:  step = line_end;
        endcase
    end

endmodule

// File: rtl/vfs_fsm.sv
module vfs_fsm
    import vfs_pkg::*;
#(
    parameter int VIS_LINES   = 404,
    parameter int FIXED_LINES = 14,
    parameter int CNT_W       = 10,
    parameter int VIS_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             line_end,
    input  logic             mid_line,
    input  logic [CNT_W-1:0] pad_last,
    input  logic [CNT_W-1:0] sync_last,
    input  logic [CNT_W-1:0] tail_last,
    output vfs_state_e       state,
    output logic             field_odd,
    output logic             fld_start,
    output logic             vblank,
    output logic             vsync,
    output logic [VIS_W-1:0] vis_line
);

    localparam logic [CNT_W-1:0] VIS_LAST = CNT_W'(VIS_LINES - 1);
    localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIXED_LINES - 1);

    vfs_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] limit;
    logic             done;
    logic             wrap;

    always_comb begin
        unique case (state)
            ST_ACTIVE: limit = VIS_LAST;
            ST_PAD:    limit = pad_last;
            ST_ALIGN:  limit = '0;
            ST_SYNC:   limit = sync_last;
            ST_TAIL:   limit = tail_last;
            ST_FIXED:  limit = FIX_LAST;
            default:   limit = '0;
        endcase
    end

    assign done = step && (cnt == limit);
    assign wrap = done && (state == ST_FIXED);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (step) begin
            if (done) begin
                cnt_nx = '0;
                unique case (state)
                    ST_ACTIVE: state_nx = ST_PAD;
                    ST_PAD:    state_nx = field_odd ? ST_ALIGN : ST_SYNC;
                    ST_ALIGN:  state_nx = ST_SYNC;
                    ST_SYNC:   state_nx = ST_TAIL;
                    ST_TAIL:   state_nx = ST_FIXED;
                    ST_FIXED:  state_nx = ST_ACTIVE;
                    default:   state_nx = ST_ACTIVE;
                endcase
            end else begin
                cnt_nx = cnt + CNT_W'(1);
            end
        end
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_ACTIVE;
            cnt       <= '0;
            field_odd <= 1'b0;
            fld_start <= 1'b1;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            fld_start <= wrap;
            if (wrap)
                field_odd <= ~field_odd;
        end
    end

    // Output process.
    always_comb begin
        vblank   = 1'b1;
        vsync    = 1'b0;
        vis_line = '0;
        unique case (state)
            ST_ACTIVE: begin
                vblank   = 1'b0;
                vis_line = VIS_W'(cnt);
            end
            ST_SYNC:   vsync = 1'b1;
            ST_PAD, ST_ALIGN, ST_TAIL, ST_FIXED: begin
                vblank = 1'b1;
            end
            default:   vblank = 1'b1;
        endcase
    end

    // R2
    vis_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && line_end && cnt != VIS_LAST)
        |=> (vis_line == $past(vis_line) + VIS_W'(1)));

    // R4
    even_sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vsync) && !field_odd) |-> $past(line_end));

    // R5
    odd_sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(vsync) || $fell(vsync)) && field_odd) |-> $past(mid_line));

    // R7
    field_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> ($fell(vblank) && $past(line_end)));

    // R9
    vblank_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> !$stable(field_odd));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_end && !mid_line) |=> ($stable(vis_line) && $stable(vsync) && $stable(vblank)));

endmodule

// File: rtl/vfield_seq.sv
module vfield_seq
    import vfs_pkg::*;
#(
    parameter int VIS_LINES   = 404,
    parameter int FIXED_LINES = 14,
    parameter int PAD_W       = 10,
    parameter int SYNC_W      = 6,
    parameter int TAIL_W      = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_end,
    input  logic                          mid_line,
    input  logic [PAD_W-1:0]              pad_len,
    input  logic [SYNC_W-1:0]             sync_len,
    input  logic [TAIL_W-1:0]             tail_len,
    output logic                          vblank,
    output logic                          vsync,
    output logic                          field_odd,
    output logic [$clog2(VIS_LINES)-1:0]  vis_line
);

    localparam int VIS_W  = $clog2(VIS_LINES);
    localparam int FIX_W  = $clog2(FIXED_LINES);
    localparam int W_A    = (PAD_W > VIS_W) ? PAD_W : VIS_W;
    localparam int W_B    = (SYNC_W > TAIL_W) ? SYNC_W : TAIL_W;
    localparam int W_C    = (W_A > W_B) ? W_A : W_B;
    localparam int CNT_W  = (W_C > FIX_W) ? W_C : FIX_W;

    vfs_state_e       state;
    logic             step;
    logic             fld_start;
    logic [CNT_W-1:0] pad_last;
    logic [CNT_W-1:0] sync_last;
    logic [CNT_W-1:0] tail_last;

    vfs_len_latch #(
        .PAD_W (PAD_W),
        .SYNC_W(SYNC_W),
        .TAIL_W(TAIL_W),
        .CNT_W (CNT_W)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fld_start),
        .pad_len  (pad_len),
        .sync_len (sync_len),
        .tail_len (tail_len),
        .pad_last (pad_last),
        .sync_last(sync_last),
        .tail_last(tail_last)
    );

    vfs_step_sel u_step (
        .state    (state),
        .field_odd(field_odd),
        .line_end (line_end),
        .mid_line (mid_line),
        .step     (step)
    );

    vfs_fsm #(
        .VIS_LINES  (VIS_LINES),
        .FIXED_LINES(FIXED_LINES),
        .CNT_W      (CNT_W),
        .VIS_W      (VIS_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .line_end (line_end),
        .mid_line (mid_line),
        .pad_last (pad_last),
        .sync_last(sync_last),
        .tail_last(tail_last),
        .state    (state),
        .field_odd(field_odd),
        .fld_start(fld_start),
        .vblank   (vblank),
        .vsync    (vsync),
        .vis_line (vis_line)
    );

endmodule

// File: tb/vfield_seq_tb.sv
module vfield_seq_tb_top;

    localparam int VIS = 404;
    localparam int FIX = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_end = 1'b0;
    logic       mid_line = 1'b0;
    logic [9:0] pad_len = 10'd9;
    logic [5:0] sync_len = 6'd9;
    logic [5:0] tail_len = 6'd13;
    logic       vblank;
    logic       vsync;
    logic       field_odd;
    logic [8:0] vis_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    int li = 0;
    int hh = 0;
    int odd_m = 0;
    int p_eff = 9;
    int s_eff = 9;
    int t_eff = 13;

    always #5 clk = ~clk;

    vfield_seq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .mid_line (mid_line),
        .pad_len  (pad_len),
        .sync_len (sync_len),
        .tail_len (tail_len),
        .vblank   (vblank),
        .vsync    (vsync),
        .field_odd(field_odd),
        .vis_line (vis_line)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_vsync(input int l, input int h, input int odd,
                                     input int p, input int s);
        int s0;
        int pos;
        s0 = VIS + p;
        if (odd == 0)
            return (l >= s0 && l < s0 + s) ? 1 : 0;
        pos = 2 * l + h;
        return (pos >= 2 * s0 + 1 && pos < 2 * (s0 + s) + 1) ? 1 : 0;
    endfunction

    task automatic cmp(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (line %0d half %0d odd %0d)",
                     tag, what, got, exp, li, hh, odd_m);
        end
    endtask

    task automatic check_all();
        int ev;
        string bt;
        ev = exp_vsync(li, hh, odd_m, p_eff, s_eff);
        if (li < VIS) bt = "R2";
        else if (li < VIS + p_eff) bt = "R3";
        else if (ev != 0) bt = (odd_m != 0) ? "R5" : "R4";
        else bt = "R6";
        cmp(li < VIS ? "R2" : "R9", "vblank", int'(vblank), (li >= VIS) ? 1 : 0);
        cmp(bt, "vsync", int'(vsync), ev);
        cmp("R7", "field_odd", int'(field_odd), odd_m);
        cmp("R2", "vis_line", int'(vis_line), (li < VIS) ? li : 0);
    endtask

    task automatic step(input logic le, input logic ml);
        line_end = le;
        mid_line = ml;
        @(negedge clk);
        line_end = 1'b0;
        mid_line = 1'b0;
    endtask

    // One scanline with random width and random midline placement.
    task automatic run_line();
        int a;
        int b;
        a = int'($urandom_range(3, 0));
        b = int'($urandom_range(3, 0));
        for (int i = 0; i < a; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        hh = 1;
        check_all();
        for (int i = 0; i < b; i++) step(1'b0, 1'b0);
        if (b > 0) check_all();
        step(1'b1, 1'b0);
        li++;
        hh = 0;
        if (li == VIS + p_eff + s_eff + t_eff + FIX) begin
            li = 0;
            odd_m = 1 - odd_m;
            p_eff = eff(int'(pad_len));
            s_eff = eff(int'(sync_len));
            t_eff = eff(int'(tail_len));
        end
        check_all();
    endtask

    // R8: lengths written mid-field only take effect in the next field.
    task automatic run_field(input int f);
        for (int n = 0; n < 50; n++) run_line();
        if (f == 0) begin
            pad_len = 10'd0; sync_len = 6'd0; tail_len = 6'd0;
        end else if (f == 1) begin
            pad_len = 10'd139; sync_len = 6'd9; tail_len = 6'd13;
        end else if (f == 2) begin
            pad_len = 10'd1023; sync_len = 6'd63; tail_len = 6'd63;
        end else begin
            pad_len = 10'($urandom_range(24, 0));
            sync_len = 6'($urandom_range(12, 0));
            tail_len = 6'($urandom_range(16, 0));
        end
        while (li != 0) run_line();
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "vblank", int'(vblank), 0);
        cmp("R1", "vsync", int'(vsync), 0);
        cmp("R1", "field_odd", int'(field_odd), 0);
        cmp("R1", "vis_line", int'(vis_line), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();
        for (int f = 0; f < 12; f++) run_field(f);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule